// File: doc/BRIEF.md
# Serial CRC Check-Bit and Syndrome Engine

This block is a parameterised Galois-form shift register that divides a serial bit stream by a fixed primitive polynomial. Each enabled clock takes one message bit, most significant (earliest) bit first. After the last bit, the parallel state output holds the remainder of the stream modulo the polynomial.

There are two ways to use it. A sender feeds a message followed by WIDTH zero bits, and the state that remains is the set of check bits. When that word (message plus check bits) is fed through again, the remainder is zero. A receiver feeds a received codeword. A nonzero result is a syndrome, and for a single flipped bit the syndrome is unique to that bit's position: it equals the remainder of an all-zero word that carries a single 1 at that position.

A zero-fill mode forces the absorbed bit to zero, whatever value the serial input carries. Once seeded with a single 1, the register in this mode steps through every nonzero state. The feedback polynomial is selected from the WIDTH parameter:
- x^4+x+1 for 4 bits.
- x^8+x^4+x^3+x^2+1 for 8 bits.

Top module: `crc_serial_engine`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state becomes all zeros on that edge, whatever `shift_en` is.
- R2: While `shift_en` is low, the state keeps its value whatever `ser_in` and `zero_fill` do.
- R3: On an enabled edge where state bit WIDTH-1 is 0 and the absorbed bit is 0, the state shifts one place toward the most significant bit, and bit 0 becomes 0.
- R4: On an enabled edge where state bit WIDTH-1 is 1, the shifted state is XORed with the tap mask. The mask is 4'b0011 for WIDTH=4 and 8'b0001_1101 for WIDTH=8, so bit k takes the feedback when the polynomial has an x^k term.
- R5: The absorbed bit is XORed into bit 0. After N bits are fed most significant first, the state equals the N-bit stream, read as a polynomial, modulo the polynomial for the width.
- R6: While `zero_fill` is high, the absorbed bit is 0 and the value on `ser_in` has no effect.
- R7: From an all-zero state with a zero absorbed bit, the state stays all zeros.
- R8: With WIDTH=4, the stream 110010001110000 leaves 1010, and the stream 110010001111010 leaves 0000.
- R9: With WIDTH=4, the second stream of R8 with its 5th bit (the 5th one fed) inverted leaves 0111. A stream of fifteen zeros with a 1 only in the 5th bit also leaves 0111.
- R10: Seeded with state 1 and run in zero-fill mode, the register passes through all 2^WIDTH-1 nonzero states, each once, and returns to 1 after exactly 2^WIDTH-1 steps.
- R11: With WIDTH=8, a 255-bit word made of 247 data bits and their 8 check bits leaves zero. The same word with one bit inverted leaves a nonzero syndrome equal to that of a lone 1 at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Absorb one bit on this edge; hold otherwise |
| ser_in | input | 1 | Serial message bit, earliest bit first |
| zero_fill | input | 1 | Force the absorbed bit to zero |
| crc_state | output | WIDTH | Remainder, check bits or syndrome |

## Verification
The assertions check the per-edge rules on every cycle:
- clearing on reset;
- holding while disabled;
- a plain shift when the top bit is clear;
- folding in the tap mask when the top bit is set in zero-fill mode;
- the zero state staying at zero;
- a nonzero state never collapsing to zero in zero-fill mode.

The remaining properties concern the result of a whole stream or a whole cycle, so only the bench scenarios can show them:
- the remainder after a long message;
- a codeword reducing to zero;
- a single error giving a position-matched syndrome;
- the full 2^WIDTH-1 period.

The bench runs the 4-bit and 8-bit builds side by side on the same stimulus. It compares both against a long-division model of the polynomial remainder.

// File: rtl/crc_lfsr_pkg.sv
// Package: crc_lfsr_pkg
// Purpose : holds the feedback tap masks of the primitive polynomials that
//           the serial CRC engine supports, indexed by register width.
// Assumes : bit k of a mask is set when the polynomial has an x^k term
//           (k < width); the leading x^width term is implied.
package crc_lfsr_pkg;

    localparam int unsigned MAX_WIDTH = 16;

    // Return the low-order tap mask for a primitive polynomial of degree w.
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int unsigned w);
        logic [MAX_WIDTH-1:0] m;
        case (w)
            2:       m = 16'h0003;  // x^2+x+1
            3:       m = 16'h0003;  // x^3+x+1
            4:       m = 16'h0003;  // x^4+x+1
            5:       m = 16'h0005;  // x^5+x^2+1
            6:       m = 16'h0003;  // x^6+x+1
            7:       m = 16'h0003;  // x^7+x+1
            8:       m = 16'h001D;  // x^8+x^4+x^3+x^2+1
            16:      m = 16'h002D;  // x^16+x^5+x^3+x^2+1
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/crc_input_gate.sv
// Module : crc_input_gate
// Purpose: picks the bit the register absorbs on this edge; in zero-fill
//          mode the serial input is replaced by a constant zero.
// Assumes: ser_in is already synchronous to the engine clock.
module crc_input_gate (
    input  logic ser_in,
    input  logic zero_fill,
    output logic absorb_bit
);

    // Mask the serial input while zero-fill mode is selected.
    always_comb begin
        absorb_bit = ser_in & ~zero_fill;
    end

endmodule

// File: rtl/crc_feedback_net.sv
// Module : crc_feedback_net
// Purpose: next-state logic of a Galois-form divider. The top state bit is
//          the feedback; each bit takes its lower neighbour, XORed with the
//          feedback where the tap mask has a 1. Bit 0 also takes the
//          absorbed serial bit.
// Assumes: TAPS has a 1 in bit 0 (every primitive polynomial has x^0).
module crc_feedback_net #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = '1
) (
    input  logic [WIDTH-1:0] cur_state,
    input  logic             absorb_bit,
    output logic [WIDTH-1:0] nxt_state
);

    logic feedback;

    // Feedback comes from the most significant flip-flop.
    always_comb begin
        feedback = cur_state[WIDTH-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            if (TAPS[0]) begin : g_tap
                assign nxt_state[0] = absorb_bit ^ feedback;
            end else begin : g_plain
                assign nxt_state[0] = absorb_bit;
            end
        end else begin : g_upper
            if (TAPS[i]) begin : g_tap
                assign nxt_state[i] = cur_state[i-1] ^ feedback;
            end else begin : g_plain
                assign nxt_state[i] = cur_state[i-1];
            end
        end
    end

endmodule

// File: rtl/crc_state_reg.sv
// Module : crc_state_reg
// Purpose: the WIDTH flip-flops of the divider, with a load enable and a
//          synchronous active-low clear that takes priority over the enable.
// Assumes: rst_n is synchronous to clk.
module crc_state_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clear on reset, load when enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/crc_serial_engine.sv
// Module : crc_serial_engine
// Purpose: serial CRC engine. On each enabled edge it absorbs one bit
//          (earliest bit first) into a Galois shift register that reduces
//          the stream modulo a fixed primitive polynomial of degree WIDTH.
//          The state is the check bits of a message or the syndrome of a
//          received codeword.
// Assumes: WIDTH is one of the widths listed in crc_lfsr_pkg::tap_mask.
module crc_serial_engine #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic             zero_fill,
    output logic [WIDTH-1:0] crc_state
);

    localparam logic [crc_lfsr_pkg::MAX_WIDTH-1:0] FULL_MASK = crc_lfsr_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS = FULL_MASK[WIDTH-1:0];

    logic             absorb_bit;
    logic [WIDTH-1:0] nxt_state;
    logic [WIDTH-1:0] cur_state;

    crc_input_gate u_gate (
        .ser_in     (ser_in),
        .zero_fill  (zero_fill),
        .absorb_bit (absorb_bit)
    );

    crc_feedback_net #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_fb (
        .cur_state  (cur_state),
        .absorb_bit (absorb_bit),
        .nxt_state  (nxt_state)
    );

    crc_state_reg #(
        .WIDTH (WIDTH)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (shift_en),
        .d     (nxt_state),
        .q     (cur_state)
    );

    // Present the register contents on the output.
    always_comb begin
        crc_state = cur_state;
    end

endmodule

// File: rtl/crc_serial_engine_checks.sv
// Module : crc_serial_engine_checks
// Purpose: per-edge properties of the serial CRC engine, bound to every
//          instance of the top module.
// Assumes: the same WIDTH and tap table as the bound engine.
module crc_serial_engine_checks #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic             zero_fill,
    input logic [WIDTH-1:0] crc_state
);

    localparam logic [crc_lfsr_pkg::MAX_WIDTH-1:0] FULL_MASK = crc_lfsr_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS = FULL_MASK[WIDTH-1:0];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> crc_state == '0);  // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(crc_state));  // R2

    AST_SHIFT_NO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && zero_fill && !crc_state[WIDTH-1]
        |=> crc_state == ($past(crc_state) << 1));  // R3

    AST_FOLD_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && zero_fill && crc_state[WIDTH-1]
        |=> crc_state == (($past(crc_state) << 1) ^ TAPS));  // R4

    AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && zero_fill && crc_state == '0 |=> crc_state == '0);  // R7

    AST_FREE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && zero_fill && crc_state != '0 |=> crc_state != '0);  // R10

endmodule

bind crc_serial_engine crc_serial_engine_checks #(.WIDTH(WIDTH)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .zero_fill (zero_fill),
    .crc_state (crc_state)
);

// File: tb/crc_serial_engine_test.sv
`timescale 1ns/1ps
// Bench: drives an 8-bit engine (uut) and a 4-bit engine (uut_w4) with the
// same stimulus and checks both against a long-division remainder model.
module crc_serial_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       zero_fill = 1'b0;
    logic [7:0] st8;
    logic [3:0] st4;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    crc_serial_engine #(.WIDTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .ser_in(ser_in), .zero_fill(zero_fill), .crc_state(st8)
    );

    crc_serial_engine #(.WIDTH(4)) uut_w4 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .ser_in(ser_in), .zero_fill(zero_fill), .crc_state(st4)
    );

    // Remainder of an n-bit stream (bit n-1 fed first) modulo the polynomial.
    function automatic logic [15:0] polymod(input logic [299:0] m, input int n, input int w);
        logic [299:0] p;
        p = (w == 4) ? 300'h13 : 300'h11D;
        for (int i = n - 1; i >= w; i--) begin
            if (m[i]) m = m ^ (p << (i - w));
        end
        return m[15:0] & ((16'h1 << w) - 16'h1);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, return at the next falling edge.
    task automatic tick(input logic en, input logic b, input logic zf);
        shift_en  = en;
        ser_in    = b;
        zero_fill = zf;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic feed(input logic [299:0] m, input int n);
        do_reset();
        for (int i = n - 1; i >= 0; i--) tick(1'b1, m[i], 1'b0);
        shift_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset 8", {8'h0, st8}, 16'h0);
        chk("R1 reset 4", {12'h0, st4}, 16'h0);
        feed(300'h5A, 8);
        do_reset();
        chk("R1 reset over enable 8", {8'h0, st8}, 16'h0);
        chk("R1 reset over enable 4", {12'h0, st4}, 16'h0);
    endtask

    task automatic t_steps();
        do_reset();
        tick(1'b1, 1'b1, 1'b0);
        chk("R5 bit into lsb 8", {8'h0, st8}, 16'h01);
        chk("R5 bit into lsb 4", {12'h0, st4}, 16'h1);
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0);
        chk("R3 plain shift 4", {12'h0, st4}, 16'h8);
        tick(1'b1, 1'b0, 1'b0);
        chk("R4 fold mask 0011", {12'h0, st4}, 16'h3);
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0);
        chk("R3 plain shift 8", {8'h0, st8}, 16'h80);
        tick(1'b1, 1'b0, 1'b0);
        chk("R4 fold mask 00011101", {8'h0, st8}, 16'h1D);
    endtask

    task automatic t_hold();
        logic [7:0] s8;
        logic [3:0] s4;
        feed(300'h3C7, 10);
        s8 = st8;
        s4 = st4;
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b1);
        tick(1'b0, 1'b1, 1'b1);
        chk("R2 hold 8", {8'h0, st8}, {8'h0, s8});
        chk("R2 hold 4", {12'h0, st4}, {12'h0, s4});
    endtask

    task automatic t_zero_fill();
        do_reset();
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b1);
        chk("R6 ser_in ignored 8", {8'h0, st8}, 16'h04);
        chk("R6 ser_in ignored 4", {12'h0, st4}, 16'h4);
        do_reset();
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 1'b0);
        chk("R7 zero stays 8", {8'h0, st8}, 16'h0);
        chk("R7 zero stays 4", {12'h0, st4}, 16'h0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1);
        chk("R7 zero stays under zero fill", {8'h0, st8}, 16'h0);
    endtask

    task automatic t_four_bit();
        feed(300'b110010001110000, 15);
        chk("R8 check bits", {12'h0, st4}, 16'hA);
        feed(300'b110010001111010, 15);
        chk("R8 codeword", {12'h0, st4}, 16'h0);
        feed(300'b110000001111010, 15);
        chk("R9 error in bit 5", {12'h0, st4}, 16'h7);
        feed(300'b000010000000000, 15);
        chk("R9 lone one", {12'h0, st4}, 16'h7);
    endtask

    task automatic t_eight_bit();
        logic [299:0] msg;
        logic [31:0]  x;
        logic [15:0]  par;
        logic [15:0]  syn;
        msg = '0;
        x = 32'h1234_5678;
        for (int i = 0; i < 247; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            msg[i + 8] = x[16];
        end
        feed(msg, 255);
        par = polymod(msg, 255, 8);
        chk("R5 remainder 8", {8'h0, st8}, par);
        chk("R5 remainder 4", {12'h0, st4}, polymod(msg, 255, 4));
        msg[7:0] = par[7:0];
        feed(msg, 255);
        chk("R11 codeword zero", {8'h0, st8}, 16'h0);
        msg[100] = ~msg[100];
        feed(msg, 255);
        syn = polymod(300'h1 << 100, 255, 8);
        chk("R11 syndrome nonzero", {15'h0, st8 != 8'h0}, 16'h1);
        chk("R11 syndrome position", {8'h0, st8}, syn);
    endtask

    task automatic t_period();
        logic [255:0] seen8;
        logic [15:0]  seen4;
        int           dup8;
        int           dup4;
        int           back4;
        int           back8;
        seen8 = '0;
        seen4 = '0;
        dup8 = 0;
        dup4 = 0;
        back4 = 0;
        back8 = 0;
        do_reset();
        tick(1'b1, 1'b1, 1'b0);
        for (int s = 1; s <= 255; s++) begin
            tick(1'b1, 1'b1, 1'b1);
            if (s <= 15) begin
                if (st4 == 4'h0 || seen4[st4]) dup4++;
                seen4[st4] = 1'b1;
                if (st4 == 4'h1 && back4 == 0) back4 = s;
            end
            if (st8 == 8'h0 || seen8[st8]) dup8++;
            seen8[st8] = 1'b1;
            if (st8 == 8'h01 && back8 == 0) back8 = s;
        end
        chk("R10 no repeat 4", dup4[15:0], 16'h0);
        chk("R10 period 4", back4[15:0], 16'd15);
        chk("R10 no repeat 8", dup8[15:0], 16'h0);
        chk("R10 period 8", back8[15:0], 16'd255);
    endtask

    initial begin
        #1_600_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        t_reset();
        t_steps();
        t_hold();
        t_zero_fill();
        t_four_bit();
        t_eight_bit();
        t_period();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule